// File: doc/BRIEF.md
# General-Purpose I/O Port with Analog Pin Claim

This block controls an 8-bit bidirectional general-purpose I/O port. A simple register bus reaches three per-pin registers: an output latch, a direction register and a pullup-enable register. For every pin the block drives an output value, an output-enable and a pullup-enable toward the pad ring. It also takes in the pad level, which passes through a two-stage synchronizer before it can be read back.

An analog converter next to the port can claim one pin as its analog input. It does this with an enable and a channel number. While a pin is claimed, the port logic gives up that pin: the output driver is off, the pullup is off and the digital read of the pin returns 0. The registers underneath keep their contents, so the pin goes back to its programmed behaviour once the claim is released.

The output latch has no reset. It holds its value through a reset, while the direction and pullup registers clear.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the direction register and the pullup register hold all zeros. Every pin_oe and pin_pu bit is therefore 0, and reads of offsets 0x5 and 0x2 return 0.
- R2: A bus write to offset 0x5 loads the direction register. A 1 in bit n drives pin_oe[n] high from the next clock edge, and a 0 drives it low, unless the pin is claimed.
- R3: A bus write to offset 0x1 loads the output latch whatever the pin directions are. pin_out always shows the latch, so a value written while a pin is an input appears on the pin once it is made an output.
- R4: Reset does not change the output latch, and pin_out keeps its value through a reset pulse.
- R5: While ana_en is 1, the pin numbered by ana_sel has pin_oe and pin_pu forced to 0, whatever its direction and pullup bits are. Reading offset 0x5 still returns the stored direction bits.
- R6: Pins not named by ana_sel, and every pin while ana_en is 0, follow the direction, pullup and latch registers unchanged.
- R7: A bus write to offset 0x2 loads the pullup register. pin_pu[n] is 1 only when pullup bit n is 1, direction bit n is 0 and pin n is not claimed.
- R8: Reading offset 0x1 returns, bit by bit, the latch value for output pins and the synchronized pad level for input pins.
- R9: A change on pad_in that is set up before clock edge k is not visible on a read after edge k. It is visible after edge k+1.
- R10: Reading offset 0x1 returns 0 in the bit of a claimed pin.
- R11: Reads of offsets other than 0x1, 0x2 and 0x5 return 0, and writes to them change no register or pin output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 3 | Register offset for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 8 | Pad input levels, asynchronous |
| ana_en | input | 1 | Converter enable; while high, the named pin is claimed |
| ana_sel | input | 3 | Pin number claimed by the converter |
| pin_out | output | 8 | Output value per pin (the latch) |
| pin_oe | output | 8 | Output-driver enable per pin |
| pin_pu | output | 8 | Pullup enable per pin |

## Verification
The bench targets the latch surviving reset. A design that reset the latch would lose pin_out after a reset pulse. It also covers a latch write made while the pins are inputs, which an over-eager design might gate off by direction.

Several checks probe the analog claim. A claimed pin whose direction bit is 1 must lose its driver and its pullup. Its read bit must be 0 even though both the pad and the latch show 1. A design that cleared the stored direction bit instead of masking it would show up in the direction read-back.

The bench also times the synchronizer to the edge: a one-stage design would show the new pad level one cycle early. Writes to unmapped offsets are checked for leaking into a real register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Register offsets. The data and direction positions are fixed by the
    // software view of the port; the pullup offset fills a free slot.
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LATCH = 3'h1,
        OFS_PULL  = 3'h2,
        OFS_DIR   = 3'h5
    } reg_ofs_e;

endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for the pad inputs, one pair of flops per pin.
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.stage1 = async_in;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_out = sync_q.stage2;

endmodule

// File: rtl/gpio_regs.sv
// Register file: direction and pullup registers with reset,
// output latch without reset.
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  latch_val,
    output logic [WIDTH-1:0]  dir_val,
    output logic [WIDTH-1:0]  pull_val
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] pull;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [WIDTH-1:0] latch_d, latch_q;

    always_comb begin
        cfg_d   = cfg_q;
        latch_d = latch_q;
        if (wr_en) begin
            unique case (wr_addr)
                OFS_LATCH: latch_d  = wr_data;
                OFS_PULL:  cfg_d.pull = wr_data;
                OFS_DIR:   cfg_d.dir  = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // The latch deliberately ignores reset.
    always_ff @(posedge clk) begin
        latch_q <= latch_d;
    end

    assign latch_val = latch_q;
    assign dir_val   = cfg_q.dir;
    assign pull_val  = cfg_q.pull;

endmodule

// File: rtl/gpio_pin_ctrl.sv
// Per-pin gating: analog claim, output enable, pullup and digital read value.
module gpio_pin_ctrl #(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3
) (
    input  logic             ana_en,
    input  logic [SEL_W-1:0] ana_sel,
    input  logic [WIDTH-1:0] latch_val,
    input  logic [WIDTH-1:0] dir_val,
    input  logic [WIDTH-1:0] pull_val,
    input  logic [WIDTH-1:0] pad_sync,
    output logic [WIDTH-1:0] oe_out,
    output logic [WIDTH-1:0] pu_out,
    output logic [WIDTH-1:0] rd_bits
);

    logic [WIDTH-1:0] claim;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_pin
        always_comb begin
            claim[gi]  = ana_en && (ana_sel == SEL_W'(gi));
            oe_out[gi] = dir_val[gi] && !claim[gi];
            pu_out[gi] = pull_val[gi] && !dir_val[gi] && !claim[gi];
            if (claim[gi]) begin
                rd_bits[gi] = 1'b0;
            end else if (dir_val[gi]) begin
                rd_bits[gi] = latch_val[gi];
            end else begin
                rd_bits[gi] = pad_sync[gi];
            end
        end
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
// 8-bit general-purpose I/O port with analog pin claim.
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEL_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    input  logic              ana_en,
    input  logic [SEL_W-1:0]  ana_sel,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_pu
);

    logic [WIDTH-1:0] latch_val;
    logic [WIDTH-1:0] dir_val;
    logic [WIDTH-1:0] pull_val;
    logic [WIDTH-1:0] pad_sync;
    logic [WIDTH-1:0] rd_bits;

    gpio_sync #(.WIDTH(WIDTH)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pad_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .latch_val (latch_val),
        .dir_val   (dir_val),
        .pull_val  (pull_val)
    );

    gpio_pin_ctrl #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_pins (
        .ana_en    (ana_en),
        .ana_sel   (ana_sel),
        .latch_val (latch_val),
        .dir_val   (dir_val),
        .pull_val  (pull_val),
        .pad_sync  (pad_sync),
        .oe_out    (pin_oe),
        .pu_out    (pin_pu),
        .rd_bits   (rd_bits)
    );

    always_comb begin
        unique case (bus_addr)
            OFS_LATCH: bus_rdata = rd_bits;
            OFS_PULL:  bus_rdata = pull_val;
            OFS_DIR:   bus_rdata = dir_val;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = latch_val;

endmodule

// File: rtl/gpio_port_chk.sv
// Property checker attached to the port controller.
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              ana_en,
    input logic [SEL_W-1:0]  ana_sel,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_pu
);

    logic [WIDTH-1:0] sel_mask;
    assign sel_mask = ana_en ? (WIDTH'(1) << ana_sel) : '0;

    AST_CLAIM_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & sel_mask) == '0); // R5

    AST_CLAIM_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & sel_mask) == '0); // R5

    AST_PULL_NOT_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0); // R7

    AST_DIR_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> pin_oe == ($past(bus_wdata) & ~sel_mask)); // R2

    AST_LATCH_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LATCH) |=> pin_out == $past(bus_wdata)); // R3

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_LATCH) |=> $stable(pin_out)); // R4

    AST_CLAIM_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_LATCH) |-> (bus_rdata & sel_mask) == '0); // R10

endmodule

bind gpio_port_ctrl gpio_port_chk #(.WIDTH(WIDTH), .SEL_W(SEL_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ana_en    (ana_en),
    .ana_sel   (ana_sel),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'h1;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic       ana_en = 1'b0;
    logic [2:0] ana_sel = 3'h0;
    logic [7:0] pin_out, pin_oe, pin_pu;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .ana_en(ana_en), .ana_sel(ana_sel), .pin_out(pin_out),
        .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    // {wr, addr, wdata, pad, ana_en, ana_sel, exp_out, exp_oe, exp_pu, exp_rd}
    localparam int NVEC = 10;
    localparam logic [55:0] VEC [NVEC] = '{
        {1'b1, 3'h1, 8'hA5, 8'h3C, 1'b0, 3'd0, 8'hA5, 8'h00, 8'h00, 8'h3C}, // R3 R8
        {1'b1, 3'h5, 8'h0F, 8'h3C, 1'b0, 3'd0, 8'hA5, 8'h0F, 8'h00, 8'h35}, // R2 R8
        {1'b1, 3'h2, 8'hFF, 8'h3C, 1'b0, 3'd0, 8'hA5, 8'h0F, 8'hF0, 8'h35}, // R7
        {1'b0, 3'h1, 8'h00, 8'h3C, 1'b1, 3'd2, 8'hA5, 8'h0B, 8'hF0, 8'h31}, // R5 R10
        {1'b0, 3'h1, 8'h00, 8'hC3, 1'b1, 3'd6, 8'hA5, 8'h0F, 8'hB0, 8'h85}, // R5 R6
        {1'b1, 3'h1, 8'h5A, 8'hC3, 1'b0, 3'd6, 8'h5A, 8'h0F, 8'hF0, 8'hCA}, // R6 R3
        {1'b1, 3'h5, 8'hF0, 8'h99, 1'b0, 3'd0, 8'h5A, 8'hF0, 8'h0F, 8'h59}, // R2
        {1'b1, 3'h4, 8'hFF, 8'h99, 1'b0, 3'd0, 8'h5A, 8'hF0, 8'h0F, 8'h59}, // R11
        {1'b0, 3'h1, 8'h00, 8'hFF, 1'b1, 3'd7, 8'h5A, 8'h70, 8'h0F, 8'h5F}, // R5
        {1'b1, 3'h2, 8'h00, 8'h00, 1'b0, 3'd0, 8'h5A, 8'hF0, 8'h00, 8'h50}  // R7
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'h1;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state while held
        check("R1 oe in reset", pin_oe, 8'h00);
        check("R1 pu in reset", pin_pu, 8'h00);
        rst_n = 1'b1;
        bus_read(3'h5, v); check("R1 dir after reset", v, 8'h00);
        bus_read(3'h2, v); check("R1 pull after reset", v, 8'h00);
        check("R1 oe after reset", pin_oe, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {bus_wr, bus_addr, bus_wdata, pad_in, ana_en, ana_sel} = VEC[i][55:32];
            @(negedge clk);
            bus_wr = 1'b0; bus_addr = 3'h1;
            @(negedge clk);
            check($sformatf("R3 R6 vec%0d pin_out", i), pin_out, VEC[i][31:24]);
            check($sformatf("R2 R5 vec%0d pin_oe", i), pin_oe, VEC[i][23:16]);
            check($sformatf("R7 R5 vec%0d pin_pu", i), pin_pu, VEC[i][15:8]);
            check($sformatf("R8 R10 vec%0d read", i), bus_rdata, VEC[i][7:0]);
        end

        // R11: unmapped write left registers intact, unmapped read is 0
        bus_read(3'h4, v); check("R11 unmapped read", v, 8'h00);
        bus_read(3'h0, v); check("R11 unmapped read 0", v, 8'h00);
        bus_read(3'h5, v); check("R11 dir intact", v, 8'hF0);

        // R5: claim on output pin keeps stored direction, R10 reads 0
        ana_en = 1'b1; ana_sel = 3'd4; pad_in = 8'hFF;
        bus_write(3'h1, 8'hFF);
        bus_read(3'h5, v); check("R5 dir read under claim", v, 8'hF0);
        check("R5 claimed oe", pin_oe, 8'hE0);
        @(negedge clk);
        bus_read(3'h1, v); check("R10 claimed bit reads 0", v, 8'hEF);
        ana_en = 1'b0;
        @(negedge clk);
        check("R6 release restores oe", pin_oe, 8'hF0);

        // R9: two-stage synchronizer timing on an input pin
        bus_write(3'h5, 8'h00);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h81;
        @(negedge clk);
        check("R9 after one edge", bus_rdata, 8'h00);
        @(negedge clk);
        check("R9 after two edges", bus_rdata, 8'h81);

        // R3: latch written while input, visible once output
        bus_write(3'h1, 8'h3E);
        check("R3 pin_out while input", pin_out, 8'h3E);
        bus_write(3'h5, 8'hFF);
        #1 check("R3 read after switch", bus_rdata, 8'h3E);

        // R4: latch survives reset; R1 direction clears
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 latch in reset", pin_out, 8'h3E);
        check("R1 oe cleared", pin_oe, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R4 latch after reset", pin_out, 8'h3E);
        bus_read(3'h2, v); check("R1 pull cleared", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule